// File: doc/BRIEF.md
# Mode-Multiplexed Output-Only Parallel Port

This block is an output-only parallel port whose pins take their value from one of two sources. When the chip runs self-contained (the single-chip and bootstrap operating modes), software owns the pins. It writes a byte into an internal data latch, and the latch drives the pins. When the chip runs with an external bus (the expanded and test operating modes), the pins are given over to the upper byte of the processor address, and the latch stops reaching them.

A register write always lands in the latch, whatever the mode, so software can prepare a value before it returns to a self-contained mode. A register read may be made at any time. It returns the value present at the pin driver input rather than a separately stored copy. In a bus mode, a read therefore returns the address byte currently on the pins.

Register access uses a single-cycle synchronous write strobe and a combinational read-data output. The mode input and the address byte come straight from the surrounding core.

Top module: `mode_mux_outport`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, the data latch becomes all zeros, and a write strobe at that edge is ignored. In a latch mode that follows, the pins read 0x00.
- R2: When `wr_en` is high at a rising edge with `rst_n` high, the latch takes `wr_data`. From that edge onward, the pins show the new value in single-chip mode (`mode` = 2'b00).
- R3: Bootstrap mode (`mode` = 2'b10) drives the pins from the latch, exactly as single-chip mode does.
- R4: In expanded mode (`mode` = 2'b01), `pin_out` equals `addr_hi` combinationally, whatever the latch holds. Mode bit 0 set means bus source; bit 0 clear means latch source.
- R5: Test mode (`mode` = 2'b11) behaves like expanded mode: `pin_out` equals `addr_hi`.
- R6: A write made in a bus mode updates the latch but does not change the pins. The written value appears on the pins as soon as the mode returns to a latch mode.
- R7: `rd_data` always equals the pin driver input. In a latch mode it returns the latch value, and in a bus mode it returns `addr_hi`.
- R8: While `wr_en` stays low, the latch holds its value. Changes on `wr_data` then have no effect on the pins in a latch mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| wr_data | input | 8 | Register write data |
| mode | input | 2 | Operating mode: 00 single-chip, 01 expanded, 10 bootstrap, 11 test |
| addr_hi | input | 8 | Upper byte of the internal address bus |
| rd_data | output | 8 | Register read data (pin driver input level) |
| pin_out | output | 8 | Port pin drive levels |

## Verification
The bench builds the port at its default width of 8 bits. At this width, every one of the 256 data values can be written and checked in both latch modes. Every one of the 256 address values can likewise be driven through both bus modes, and each bus-mode write is followed by a return to a latch mode. This covers all data patterns, both directions of each mode switch, and the reset-time write conflict.

// File: rtl/outport_pkg.sv
// Package: shared mode encoding and source-selection helper for the
// mode-multiplexed output port. Assumes a two-bit mode field where bit 0
// set means the external bus owns the pins.
package outport_pkg;

    typedef enum logic [1:0] {
        OPM_SINGLE = 2'b00,
        OPM_BUS    = 2'b01,
        OPM_BOOT   = 2'b10,
        OPM_TEST   = 2'b11
    } opmode_e;

    // True when the operating mode hands the pins to the address bus.
    function automatic logic mode_uses_bus(input opmode_e m);
        logic r;
        case (m)
            OPM_SINGLE: r = 1'b0;
            OPM_BOOT:   r = 1'b0;
            OPM_BUS:    r = 1'b1;
            OPM_TEST:   r = 1'b1;
            default:    r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/outport_latch.sv
// Module: software data latch for the output port.
// Captures write data on every strobe regardless of mode; clears on a
// synchronous active-low reset, which wins over a concurrent write.
module outport_latch #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] q
);

    localparam logic [WIDTH-1:0] RESET_VAL = '0;

    // Hold or update the stored byte, clearing it under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RESET_VAL;
        end else if (wr_en) begin
            q <= wr_data;
        end
    end

endmodule

// File: rtl/outport_mux.sv
// Module: per-bit source selector for the port pins.
// Chooses between the latch and the address byte; assumes sel_bus is a
// clean one-bit decode of the operating mode.
module outport_mux #(
    parameter int WIDTH = 8
) (
    input  logic             sel_bus,
    input  logic [WIDTH-1:0] latch_val,
    input  logic [WIDTH-1:0] bus_val,
    output logic [WIDTH-1:0] drv
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        // Route one pin from the chosen source.
        always_comb begin
            drv[b] = sel_bus ? bus_val[b] : latch_val[b];
        end
    end

endmodule

// File: rtl/mode_mux_outport.sv
// Module: top of the mode-multiplexed output-only port.
// Pins follow the software latch in single-chip and bootstrap modes and the
// upper address byte in expanded and test modes. Reads return the driver
// input. Assumes mode and addr_hi are stable, synchronous core signals.
module mode_mux_outport #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [1:0]       mode,
    input  logic [WIDTH-1:0] addr_hi,
    output logic [WIDTH-1:0] rd_data,
    output logic [WIDTH-1:0] pin_out
);

    import outport_pkg::*;

    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] drv_in;
    logic             sel_bus;

    // Decode the operating mode into a pin-source select.
    always_comb begin
        sel_bus = mode_uses_bus(opmode_e'(mode));
    end

    outport_latch #(.WIDTH(WIDTH)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .q       (latch_q)
    );

    outport_mux #(.WIDTH(WIDTH)) u_mux (
        .sel_bus   (sel_bus),
        .latch_val (latch_q),
        .bus_val   (addr_hi),
        .drv       (drv_in)
    );

    // Drive the pins and the read path from the same driver input.
    always_comb begin
        pin_out = drv_in;
        rd_data = drv_in;
    end

endmodule

// File: rtl/mode_mux_outport_chk.sv
// Module: assertion checker for mode_mux_outport, attached by bind.
// Relates the port-level inputs and outputs over time.
module mode_mux_outport_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [WIDTH-1:0] wr_data,
    input logic [1:0]       mode,
    input logic [WIDTH-1:0] addr_hi,
    input logic [WIDTH-1:0] rd_data,
    input logic [WIDTH-1:0] pin_out
);

    logic lmode;

    // Latch-sourced modes are those with mode bit 0 clear.
    always_comb begin
        lmode = (mode == 2'b00) || (mode == 2'b10);
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (lmode -> (pin_out == '0))); // R1

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (lmode -> (pin_out == $past(wr_data)))); // R2

    AST_BUS_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        !lmode |-> (pin_out == addr_hi)); // R4

    AST_BUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !lmode |-> (rd_data == addr_hi)); // R7

    AST_READ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (lmode -> (rd_data == $past(wr_data)))); // R7

    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && lmode) |=> (lmode -> $stable(pin_out))); // R8

endmodule

bind mode_mux_outport mode_mux_outport_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .mode    (mode),
    .addr_hi (addr_hi),
    .rd_data (rd_data),
    .pin_out (pin_out)
);

// File: tb/mode_mux_outport_bench.sv
// Bench: sweeps every data and address byte through all four modes.
module mode_mux_outport_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [1:0] mode;
    logic [7:0] addr_hi;
    logic [7:0] rd_data;
    logic [7:0] pin_out;

    int checks = 0;
    int failures = 0;
    logic [7:0] model_latch;

    always #10 clk = ~clk;

    mode_mux_outport u_mode_mux_outport (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .mode    (mode),
        .addr_hi (addr_hi),
        .rd_data (rd_data),
        .pin_out (pin_out)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] expect_pin(input logic [1:0] m, input logic [7:0] a,
                                              input logic [7:0] l);
        return m[0] ? a : l;
    endfunction

    task automatic do_write(input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        model_latch = v;
    endtask

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        wr_en = 1'b1;
        wr_data = 8'hFF;
        mode = 2'b00;
        addr_hi = 8'h3C;
        repeat (3) @(negedge clk);
        wr_en = 1'b0;
        rst_n = 1'b1;
        model_latch = 8'h00;
        #1;
        check("R1 pin after reset", pin_out, 8'h00);
        check("R1 read after reset", rd_data, 8'h00);

        // R2 R3 R7: every data byte in both latch modes.
        for (int mi = 0; mi < 2; mi++) begin
            mode = (mi == 0) ? 2'b00 : 2'b10;
            for (int v = 0; v < 256; v++) begin
                addr_hi = 8'(v) ^ 8'h5A;
                do_write(8'(v));
                #1;
                check(mi == 0 ? "R2 pin after write" : "R3 boot pin after write",
                      pin_out, expect_pin(mode, addr_hi, model_latch));
                check("R7 read equals latch", rd_data, 8'(v));
                // R8: data wiggles without strobe.
                wr_data = ~8'(v);
                @(negedge clk);
                #1;
                check("R8 hold without strobe", pin_out, 8'(v));
            end
        end

        // R4 R5 R6 R7: every address byte in both bus modes.
        for (int mi = 0; mi < 2; mi++) begin
            for (int a = 0; a < 256; a++) begin
                mode = (mi == 0) ? 2'b01 : 2'b11;
                addr_hi = 8'(a);
                #1;
                check(mi == 0 ? "R4 expanded pins" : "R5 test pins", pin_out, 8'(a));
                check("R7 bus read", rd_data, 8'(a));
                do_write(8'(a) ^ 8'hC3);
                #1;
                check("R6 bus pins unchanged by write", pin_out, 8'(a));
                mode = (a % 2 == 0) ? 2'b00 : 2'b10;
                #1;
                check("R6 latch visible after return", pin_out, 8'(a) ^ 8'hC3);
            end
        end

        // R1: reset clears a nonzero latch, write in reset ignored.
        do_write(8'hA7);
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b1;
        wr_data = 8'h99;
        @(negedge clk);
        rst_n = 1'b1;
        wr_en = 1'b0;
        mode = 2'b10;
        #1;
        check("R1 reset over write", pin_out, 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule